// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel running in waveform mode. One 16-bit up-counter drives two output pins, A and B. The compare register RC sets a period that both pins share. Each pin also has its own compare register: RA for pin A and RB for pin B. A mode word gives every pin three small action fields: one for its own compare match, one for the period match and one for a software trigger. Each field can leave the pin alone, drive it high, drive it low or invert it. The usual settings for these fields give normal-polarity PWM, inverted PWM, a duty of 0 or a full duty, all from the same hardware.

Software programs the channel through a small word-wide register port. There are four registers that can be read back (mode, RA, RB, RC) and one write-only command register. The command register starts the counter, stops it, or fires a software trigger. A software trigger zeroes the counter and forces the trigger levels onto both pins. The counter advances only on cycles when the tick enable is high. Five prescaled tick enables arrive from outside the block, and a field in the mode word selects one of them.

Top module: `wave_timer_ch`

## Requirements
- R1: After a synchronous active-low reset, both pins are low, the counter is zero and stopped, and every readable register returns 0.
- R2: Writes to address 0 (mode), 1 (RA), 2 (RB) and 3 (RC) read back unchanged from the same addresses on the next cycle. Address 4 (command) reads 0.
- R3: In a command write, bit 0 starts counting and bit 1 stops it. If both bits are set, stop wins. While the counter is stopped it holds its value and both pins keep their levels.
- R4: While counting, the counter adds one on each selected tick. On the tick where it equals RC, it returns to 0 instead, so one period is RC+1 ticks.
- R5: Mode bits [2:0] choose the tick source. The values 0 to 4 pick `tick_src[0]` to `tick_src[4]`, and the values 5 to 7 give no ticks at all.
- R6: Every action field is coded as 0 = keep the level, 1 = drive high, 2 = drive low, 3 = invert.
- R7: Pin A takes its RA-match action from mode bits [4:3], its RC-match action from bits [6:5] and its trigger action from bits [8:7]. Pin B takes its RB-match action from bits [10:9], its RC-match action from bits [12:11] and its trigger action from bits [14:13]. Bit 15 is a spare bit that is stored.
- R8: Command bit 2 is the software trigger. In the next cycle it zeroes the counter and applies each pin's trigger action. On that cycle it overrides any compare event.
- R9: If a pin's own compare match and the RC match fall on the same tick, only the RC action is applied to that pin.
- R10: Compare events happen only on ticks while counting. A new RA, RB or RC value is used from the cycle after it is written.
- R11: Setting the compare action to drive low and the RC action to drive high gives a pin that is high for (compare value + 1) of every RC+1 ticks. Swapping the two actions inverts the pin. Setting both compare actions to keep the level holds the level set by the last trigger, which gives a duty of 0 or a full duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data, combinational |
| tick_src | input | 5 | Prescaled tick enables |
| out_a | output | 1 | Waveform pin A |
| out_b | output | 1 | Waveform pin B |

## Verification
The bench builds the channel with its defaults: a 16-bit counter, a 16-bit data word and five tick sources. The bench drives its own tick sources, which fire every 1, 2, 4, 8 and 16 cycles. With these sources and small RC values, many full periods run within a few hundred cycles. Sources slower than every cycle show that the counter advances only on selected ticks, and the unused select values 5 to 7 show a channel that never ticks. Because the counter is 16 bits wide, a wrap past RC would take 65536 ticks. The bench therefore keeps compare values close to the count.

// File: rtl/wt_pkg.sv
// Shared types for the waveform timer channel: action codes, the mode
// word layout, register addresses and command bit positions.
// Assumes the mode word fits in the data bus of the top module.
package wt_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } act_e;

    typedef struct packed {
        logic       spare;
        act_e       b_sw;
        act_e       b_rc;
        act_e       b_cmp;
        act_e       a_sw;
        act_e       a_rc;
        act_e       a_cmp;
        logic [2:0] clk_sel;
    } mode_t;

    localparam int MODE_W       = $bits(mode_t);
    localparam int SEL_W        = 3;
    localparam int ADR_MODE     = 0;
    localparam int ADR_RA       = 1;
    localparam int ADR_RB       = 2;
    localparam int ADR_RC       = 3;
    localparam int ADR_CMD      = 4;
    localparam int CMD_EN_BIT   = 0;
    localparam int CMD_DIS_BIT  = 1;
    localparam int CMD_TRIG_BIT = 2;

    // Next level of a pin under the given action.
    function automatic logic apply_act(act_e act, logic cur);
        logic nxt;
        unique case (act)
            ACT_SET: nxt = 1'b1;
            ACT_CLR: nxt = 1'b0;
            ACT_TOG: nxt = ~cur;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wt_regs.sv
// Register file of the channel: stores the mode word and the three compare
// values, decodes command writes into single-cycle pulses and serves reads.
// Assumes DATA_W >= CNT_W and DATA_W >= MODE_W.
module wt_regs
    import wt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  ra_o,
    output logic [CNT_W-1:0]  rb_o,
    output logic [CNT_W-1:0]  rc_o,
    output logic              cmd_en,
    output logic              cmd_dis,
    output logic              cmd_trig
);

    logic cmd_sel;

    // Store the writable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
            ra_o   <= '0;
            rb_o   <= '0;
            rc_o   <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_MODE)) mode_o <= mode_t'(wr_data[MODE_W-1:0]);
            if (wr_addr == ADDR_W'(ADR_RA))   ra_o   <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_RB))   rb_o   <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_RC))   rc_o   <= wr_data[CNT_W-1:0];
        end
    end

    // Decode a command write into its pulses.
    always_comb begin
        cmd_sel  = wr_en && (wr_addr == ADDR_W'(ADR_CMD));
        cmd_en   = cmd_sel && wr_data[CMD_EN_BIT];
        cmd_dis  = cmd_sel && wr_data[CMD_DIS_BIT];
        cmd_trig = cmd_sel && wr_data[CMD_TRIG_BIT];
    end

    // Read multiplexer; the command address and unused addresses read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(ADR_MODE)) rd_data = DATA_W'(mode_o);
        if (rd_addr == ADDR_W'(ADR_RA))   rd_data = DATA_W'(ra_o);
        if (rd_addr == ADDR_W'(ADR_RB))   rd_data = DATA_W'(rb_o);
        if (rd_addr == ADDR_W'(ADR_RC))   rd_data = DATA_W'(rc_o);
    end

endmodule

// File: rtl/wt_tick_sel.sv
// Picks one of N_SRC prescaled tick enables. Select values at or above
// N_SRC give no tick. Assumes each source is a one-cycle enable.
module wt_tick_sel #(
    parameter int N_SRC = 5,
    parameter int SEL_W = 3
) (
    input  logic [N_SRC-1:0] src,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // Scan the sources for the selected one.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = src[i];
        end
    end

endmodule

// File: rtl/wt_counter.sv
// Up-counter with automatic return to zero after reaching the period value.
// Holds the run state set and cleared by commands. A software trigger zeroes
// the count. Assumes the command pulses last one cycle.
module wt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_trig,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             tick_ev,
    output logic             rc_hit
);

    // Qualify ticks with the run state and detect the period match.
    always_comb begin
        tick_ev = run && tick;
        rc_hit  = tick_ev && (cnt == period);
    end

    // Update the run state and the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else begin
            if (cmd_dis)     run <= 1'b0;
            else if (cmd_en) run <= 1'b1;
            if (cmd_trig)     cnt <= '0;
            else if (rc_hit)  cnt <= '0;
            else if (tick_ev) cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wt_out_ctl.sv
// One waveform pin. Applies the trigger action, then the period-match
// action, then the own-compare action, in that order of priority.
// Assumes the event inputs already include tick and run qualification.
module wt_out_ctl
    import wt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic rc_hit,
    input  logic cmp_hit,
    input  act_e act_sw,
    input  act_e act_rc,
    input  act_e act_cmp,
    output logic pin
);

    // Apply the highest-priority event of this cycle to the pin.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin <= 1'b0;
        else if (trig)    pin <= apply_act(act_sw, pin);
        else if (rc_hit)  pin <= apply_act(act_rc, pin);
        else if (cmp_hit) pin <= apply_act(act_cmp, pin);
    end

endmodule

// File: rtl/wave_timer_ch.sv
// Top of the dual-output waveform timer channel. It connects the register
// file, the tick select, the shared counter and one pin controller per
// output. Assumes the tick sources are enables that are synchronous to clk.
module wave_timer_ch
    import wt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int N_SRC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SRC-1:0]  tick_src,
    output logic              out_a,
    output logic              out_b
);

    localparam int N_OUT = 2;

    mode_t            mode_q;
    logic [CNT_W-1:0] ra_q, rb_q, rc_q, cnt_q;
    logic             cmd_en, cmd_dis, sw_fire;
    logic             tick, run_q, tick_ev, rc_hit;
    logic [CNT_W-1:0] cmp_val [N_OUT];
    act_e             act_cmp [N_OUT];
    act_e             act_rc  [N_OUT];
    act_e             act_sw  [N_OUT];
    logic [N_OUT-1:0] cmp_hit;
    logic [N_OUT-1:0] pins;

    wt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .mode_o(mode_q), .ra_o(ra_q), .rb_o(rb_q), .rc_o(rc_q),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(sw_fire)
    );

    wt_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_tick (
        .src(tick_src), .sel(mode_q.clk_sel), .tick(tick)
    );

    wt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_en(cmd_en),
        .cmd_dis(cmd_dis), .cmd_trig(sw_fire), .period(rc_q),
        .cnt(cnt_q), .run(run_q), .tick_ev(tick_ev), .rc_hit(rc_hit)
    );

    // Route each pin's compare value and action fields.
    always_comb begin
        cmp_val[0] = ra_q;          cmp_val[1] = rb_q;
        act_cmp[0] = mode_q.a_cmp;  act_cmp[1] = mode_q.b_cmp;
        act_rc[0]  = mode_q.a_rc;   act_rc[1]  = mode_q.b_rc;
        act_sw[0]  = mode_q.a_sw;   act_sw[1]  = mode_q.b_sw;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_pin
        // Detect this pin's own compare match on a counting tick.
        always_comb cmp_hit[g] = tick_ev && (cnt_q == cmp_val[g]);

        wt_out_ctl u_out (
            .clk(clk), .rst_n(rst_n), .trig(sw_fire), .rc_hit(rc_hit),
            .cmp_hit(cmp_hit[g]), .act_sw(act_sw[g]), .act_rc(act_rc[g]),
            .act_cmp(act_cmp[g]), .pin(pins[g])
        );
    end

    assign out_a = pins[0];
    assign out_b = pins[1];

endmodule

// File: rtl/wt_checker.sv
// Property checker for the waveform timer channel, bound to the top module.
module wt_checker
    import wt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic             run,
    input logic             tick_ev,
    input logic             rc_hit,
    input logic             sw_fire,
    input act_e             a_rc,
    input logic             out_a,
    input logic             out_b
);

    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && !run && !out_a && !out_b));

    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc_hit && !sw_fire |=> cnt == '0);

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_ev && !rc_hit && !sw_fire |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R8
    trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fire |=> cnt == '0);

    // R3
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ev && !sw_fire |=> $stable(cnt));

    // R10
    quiet_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_ev && !sw_fire |=> $stable(out_a) && $stable(out_b));

    // R9
    rc_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc_hit && !sw_fire && a_rc == ACT_SET |=> out_a);

endmodule

bind wave_timer_ch wt_checker #(.CNT_W(CNT_W)) u_wt_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .run(run_q), .tick_ev(tick_ev),
    .rc_hit(rc_hit), .sw_fire(sw_fire), .a_rc(mode_q.a_rc),
    .out_a(out_a), .out_b(out_b)
);

// File: tb/wave_timer_ch_bench.sv
`timescale 1ns/1ps
module wave_timer_ch_bench;

    localparam int CNT_W = 16, DATA_W = 16, ADDR_W = 3, N_SRC = 5;
    localparam int HOLD = 0, SETH = 1, CLRL = 2, TOGL = 3;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [N_SRC-1:0]  tick_src;
    logic              out_a, out_b;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    live = 0, done = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_mode, m_ra, m_rb, m_rc, m_cnt;
    bit m_run, m_a, m_b;

    always #2.5 clk = ~clk;

    wave_timer_ch #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SRC(N_SRC))
    u_wave_timer_ch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_src(tick_src), .out_a(out_a), .out_b(out_b)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit act_of(int code, bit cur);
        case (code)
            SETH:    return 1'b1;
            CLRL:    return 1'b0;
            TOGL:    return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic int mk_mode(int sel, int ac, int arc, int asw, int bc, int brc, int bsw);
        return sel | (ac << 3) | (arc << 5) | (asw << 7) | (bc << 9) | (brc << 11) | (bsw << 13);
    endfunction

    function automatic int model_rd(int a);
        case (a)
            0: return m_mode;
            1: return m_ra;
            2: return m_rb;
            3: return m_rc;
            default: return 0;
        endcase
    endfunction

    // Tick sources: every 1, 2, 4, 8 and 16 cycles.
    always @(negedge clk) begin
        cyc++;
        tick_src[0] = 1'b1;
        tick_src[1] = (cyc % 2) == 0;
        tick_src[2] = (cyc % 4) == 0;
        tick_src[3] = (cyc % 8) == 0;
        tick_src[4] = (cyc % 16) == 0;
    end

    // Behavioural reference model, advanced on every rising edge.
    always @(posedge clk) begin : model
        int sel; bit tk, ev, sw, en, dis, iscmd, hc, ha, hb;
        if (!rst_n) begin
            m_mode = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_cnt = 0;
            m_run = 0; m_a = 0; m_b = 0;
        end else begin
            sel   = m_mode & 7;
            tk    = (sel < N_SRC) ? tick_src[sel] : 1'b0;
            ev    = m_run && tk;
            iscmd = wr_en && (wr_addr == 3'd4);
            en    = iscmd && wr_data[0];
            dis   = iscmd && wr_data[1];
            sw    = iscmd && wr_data[2];
            hc    = ev && (m_cnt == m_rc);
            ha    = ev && (m_cnt == m_ra);
            hb    = ev && (m_cnt == m_rb);
            if (sw)      m_a = act_of((m_mode >> 7) & 3, m_a);
            else if (hc) m_a = act_of((m_mode >> 5) & 3, m_a);
            else if (ha) m_a = act_of((m_mode >> 3) & 3, m_a);
            if (sw)      m_b = act_of((m_mode >> 13) & 3, m_b);
            else if (hc) m_b = act_of((m_mode >> 11) & 3, m_b);
            else if (hb) m_b = act_of((m_mode >> 9) & 3, m_b);
            if (sw)      m_cnt = 0;
            else if (hc) m_cnt = 0;
            else if (ev) m_cnt = (m_cnt + 1) % 65536;
            if (dis)     m_run = 0;
            else if (en) m_run = 1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_mode = wr_data;
                    3'd1: m_ra   = wr_data;
                    3'd2: m_rb   = wr_data;
                    3'd3: m_rc   = wr_data;
                    default: ;
                endcase
            end
        end
    end

    // Compare the design with the model shortly after every edge.
    always @(posedge clk) begin
        #1;
        if (live) begin
            chk({cur_req, " pin A"}, out_a, m_a);
            chk({cur_req, " pin B"}, out_b, m_b);
            chk({cur_req, " read"}, rd_data, model_rd(rd_addr));
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        rd_addr = ADDR_W'(a);
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic run_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_high(int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += out_a; hb += out_b;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ha, hb; bit la, lb;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        tick_src = '0;
        run_cycles(3);
        // R1 reset state at the ports
        chk("R1 pin A", out_a, 0);
        chk("R1 pin B", out_b, 0);
        for (int a = 0; a < 5; a++) rd_chk("R1 read", a, 0);
        rst_n = 1'b1;
        live = 1;

        // R2 register readback
        cur_req = "R2";
        wr(0, 16'hA5C3); wr(1, 1234); wr(2, 16'hBEEF); wr(3, 16'h00FF);
        rd_chk("R2 mode", 0, 16'hA5C3);
        rd_chk("R2 RA", 1, 1234);
        rd_chk("R2 RB", 2, 16'hBEEF);
        rd_chk("R2 RC", 3, 16'h00FF);
        rd_chk("R2 cmd", 4, 0);
        rd_addr = 3'd1;

        // R11 / R7: A normal polarity, B inverted, period 8 ticks
        cur_req = "R11";
        wr(0, mk_mode(0, CLRL, SETH, SETH, SETH, CLRL, CLRL));
        wr(1, 2); wr(2, 4); wr(3, 7);
        wr(4, 3'b101);
        chk("R8 trigger level A", out_a, 1);
        chk("R8 trigger level B", out_b, 0);
        run_cycles(4);
        count_high(16, ha, hb);
        chk("R11 A high count", ha, 6);
        chk("R7 B high count", hb, 6);

        // R9: own compare and period match on the same tick
        cur_req = "R9";
        wr(0, mk_mode(0, TOGL, SETH, CLRL, TOGL, CLRL, SETH));
        wr(1, 5); wr(2, 5); wr(3, 5);
        wr(4, 3'b101);
        run_cycles(30);
        chk("R9 A rc wins", out_a, 1);
        chk("R9 B rc wins", out_b, 0);

        // R5: slower tick source, then a select with no ticks
        cur_req = "R5";
        wr(0, mk_mode(2, CLRL, SETH, SETH, SETH, CLRL, CLRL));
        wr(1, 2); wr(2, 4); wr(3, 7);
        wr(4, 3'b101);
        count_high(64, ha, hb);
        chk("R5 A high count sel2", ha, 24);
        wr(0, mk_mode(6, CLRL, SETH, SETH, SETH, CLRL, CLRL));
        la = out_a; lb = out_b;
        run_cycles(40);
        chk("R5 A frozen sel6", out_a, la);
        chk("R5 B frozen sel6", out_b, lb);

        // R3: stop, start+stop together, resume
        cur_req = "R3";
        wr(0, mk_mode(0, CLRL, SETH, SETH, SETH, CLRL, CLRL));
        wr(4, 3'b101);
        run_cycles(5);
        wr(4, 3'b010);
        la = out_a; lb = out_b;
        run_cycles(30);
        chk("R3 A held", out_a, la);
        chk("R3 B held", out_b, lb);
        wr(4, 3'b011);
        run_cycles(20);
        chk("R3 A held dual", out_a, la);
        chk("R3 B held dual", out_b, lb);
        wr(4, 3'b001);
        run_cycles(20);

        // R8: trigger mid-period while running
        cur_req = "R8";
        run_cycles(3);
        wr(4, 3'b100);
        chk("R8 A forced", out_a, 1);
        chk("R8 B forced", out_b, 0);
        run_cycles(20);

        // R6: toggle actions
        cur_req = "R6";
        wr(0, mk_mode(0, HOLD, TOGL, HOLD, TOGL, HOLD, HOLD));
        wr(1, 0); wr(2, 1); wr(3, 3);
        wr(4, 3'b101);
        count_high(32, ha, hb);
        chk("R6 A toggle count", ha, 16);
        chk("R6 B toggle count", hb, 16);

        // R11: duty 0 on A, full duty on B
        cur_req = "R11";
        wr(0, mk_mode(0, HOLD, HOLD, CLRL, HOLD, HOLD, SETH));
        wr(4, 3'b101);
        count_high(20, ha, hb);
        chk("R11 duty zero", ha, 0);
        chk("R11 duty full", hb, 20);

        // R10: compare value changed mid-run, then stopped with matching count
        cur_req = "R10";
        wr(0, mk_mode(0, CLRL, SETH, SETH, SETH, CLRL, CLRL));
        wr(1, 2); wr(2, 4); wr(3, 9);
        wr(4, 3'b101);
        run_cycles(4);
        wr(1, 6);
        run_cycles(30);
        wr(4, 3'b010);
        wr(1, 0); wr(2, 0); wr(3, 0);
        la = out_a; lb = out_b;
        run_cycles(20);
        chk("R10 A no compare stopped", out_a, la);
        chk("R10 B no compare stopped", out_b, lb);

        run_cycles(2);
        live = 0;
        finish_run();
    end

endmodule